// File: doc/BRIEF.md
# Two-Class Priority Interrupt Arbiter

This block chooses one winning interrupt line for each of two request classes: a normal class and a fast class. Every line carries a pending flag, a mask flag, a class-routing flag and a priority number. A line can compete only in the class its routing flag selects, and only while it is pending and unmasked. A smaller priority number is more urgent. When several eligible lines share the smallest number, the line with the largest index wins.

Each class has a re-arm flag. While the flag is set, and the global enable is high, and at least one line is eligible, the block latches the winner's code and raises that class's request output. The same edge clears the flag. The code and the request then stay frozen until software sends a re-arm pulse for that class. That pulse drops the request, sets the flag again and evaluates the class at once. Register decoding and input sensing sit outside this block. Their results arrive here as state vectors and pulses.

Top module: `prio_irq_arbiter`

## Requirements
- R1: While `rst_n` is low, both request outputs are 0 and both codes are 0. Both re-arm flags leave reset set.
- R2: A line is eligible for the fast class when pend=1, mask=0 and route_fast=1. It is eligible for the normal class when pend=1, mask=0 and route_fast=0. No other line affects that class.
- R3: Among eligible lines, a numerically smaller priority value always wins.
- R4: Among eligible lines of equal priority, the highest line index wins, across bank boundaries too.
- R5: The code of line bit b in bank k is 32*k + b, which is the line's flat index in the input vectors.
- R6: A class fires when its re-arm flag is set, one of its lines is eligible and `global_en` is 1. It fires with no further pulse if the eligibility appears later. Firing raises the request and loads the code one clock after the sampling edge, and it clears the re-arm flag.
- R7: After a class fires, its request stays 1 and its code stays unchanged until a re-arm pulse for that class, even while pending, mask or priority inputs change.
- R8: A re-arm pulse drops the request unless a new firing happens on the same edge. A new firing happens if a line is eligible and `global_en` is 1. It raises the request and loads a fresh code.
- R9: A re-arm pulse for one class has no effect on the other class's request or code.
- R10: While `global_en` is 0, no class fires. The re-arm flag is kept, so the class fires once `global_en` returns to 1.

Line i's priority occupies `prio_vec[i*PRIO_W +: PRIO_W]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pend | input | NUM_BANKS*32 | Pending flag per line |
| mask | input | NUM_BANKS*32 | Mask flag per line (1 = blocked) |
| route_fast | input | NUM_BANKS*32 | Class routing per line (1 = fast, 0 = normal) |
| prio_vec | input | NUM_BANKS*32*PRIO_W | Packed priority per line, 0 most urgent |
| global_en | input | 1 | Global enable for raising requests |
| rearm_norm | input | 1 | Re-arm pulse, normal class |
| rearm_fast | input | 1 | Re-arm pulse, fast class |
| req_norm | output | 1 | Registered request, normal class |
| req_fast | output | 1 | Registered request, fast class |
| code_norm | output | clog2(NUM_BANKS*32) | Latched winner code, normal class |
| code_fast | output | clog2(NUM_BANKS*32) | Latched winner code, fast class |

## Verification
The bench moves a single eligible line across all 96 positions in alternating classes. This exposes a wrong bank offset in the code or a routing polarity swap, which would report a wrong index or raise the wrong class. Random patterns with only four priority levels produce many ties. A design that breaks ties toward the low index, or compares with a strict inequality in the tree, would report a lower line than the model. Directed sequences check three more faults. Firing on a pending change after the flag has cleared would make the code drift during hold. A re-arm that leaks into the other class would move that class's code. Losing the re-arm flag while the global enable is low would leave the request low after enable returns.

// File: rtl/prio_irq_arbiter.sv
module prio_irq_arbiter #(
  parameter int NUM_BANKS = 3,
  parameter int PRIO_W    = 6
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic [NUM_BANKS*32-1:0]               pend,
  input  logic [NUM_BANKS*32-1:0]               mask,
  input  logic [NUM_BANKS*32-1:0]               route_fast,
  input  logic [NUM_BANKS*32*PRIO_W-1:0]        prio_vec,
  input  logic                                  global_en,
  input  logic                                  rearm_norm,
  input  logic                                  rearm_fast,
  output logic                                  req_norm,
  output logic                                  req_fast,
  output logic [$clog2(NUM_BANKS*32)-1:0]       code_norm,
  output logic [$clog2(NUM_BANKS*32)-1:0]       code_fast
);

  localparam int N      = NUM_BANKS * 32;
  localparam int CODE_W = $clog2(N);
  localparam int P      = 1 << CODE_W;

  logic [1:0] rearm;
  assign rearm = {rearm_fast, rearm_norm};

  for (genvar c = 0; c < 2; c++) begin : g_cls
    logic [N-1:0]      elig;
    logic [2*P-1:1]    nv;
    logic [PRIO_W-1:0] np [1:2*P-1];
    logic [CODE_W-1:0] ni [1:2*P-1];
    logic              armed, req_q, fire;
    logic [CODE_W-1:0] code_q, win;

    assign elig = pend & ~mask & ((c == 1) ? route_fast : ~route_fast);

    for (genvar i = 0; i < P; i++) begin : g_leaf
      if (i < N) begin : g_real
        assign nv[P+i] = elig[i];
        assign np[P+i] = prio_vec[i*PRIO_W +: PRIO_W];
      end else begin : g_pad
        assign nv[P+i] = 1'b0;
        assign np[P+i] = '1;
      end
      assign ni[P+i] = CODE_W'(i);
    end

    for (genvar k = 1; k < P; k++) begin : g_node
      logic take_hi;
      assign take_hi = nv[2*k+1] && (!nv[2*k] || np[2*k+1] <= np[2*k]);
      assign nv[k] = nv[2*k] | nv[2*k+1];
      assign np[k] = take_hi ? np[2*k+1] : np[2*k];
      assign ni[k] = take_hi ? ni[2*k+1] : ni[2*k];
    end

    assign win  = nv[1] ? ni[1] : '0;
    assign fire = (armed | rearm[c]) & nv[1] & global_en;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        armed  <= 1'b1;
        req_q  <= 1'b0;
        code_q <= '0;
      end else if (fire) begin
        armed  <= 1'b0;
        req_q  <= 1'b1;
        code_q <= win;
      end else if (rearm[c]) begin
        armed  <= 1'b1;
        req_q  <= 1'b0;
      end
    end
  end

  assign req_norm  = g_cls[0].req_q;
  assign req_fast  = g_cls[1].req_q;
  assign code_norm = g_cls[0].code_q;
  assign code_fast = g_cls[1].code_q;

endmodule

// File: rtl/prio_irq_arbiter_chk.sv
module prio_irq_arbiter_chk #(
  parameter int NUM_BANKS = 3,
  parameter int PRIO_W    = 6
) (
  input logic                                  clk,
  input logic                                  rst_n,
  input logic [NUM_BANKS*32-1:0]               pend,
  input logic [NUM_BANKS*32-1:0]               mask,
  input logic [NUM_BANKS*32-1:0]               route_fast,
  input logic [NUM_BANKS*32*PRIO_W-1:0]        prio_vec,
  input logic                                  global_en,
  input logic                                  rearm_norm,
  input logic                                  rearm_fast,
  input logic                                  req_norm,
  input logic                                  req_fast,
  input logic [$clog2(NUM_BANKS*32)-1:0]       code_norm,
  input logic [$clog2(NUM_BANKS*32)-1:0]       code_fast
);

  logic any_norm, any_fast;
  logic unused_ok;
  assign any_norm  = |(pend & ~mask & ~route_fast);
  assign any_fast  = |(pend & ~mask & route_fast);
  assign unused_ok = ^prio_vec;

  AST_NORM_CODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    req_norm && !rearm_norm |=> $stable(code_norm));                 // R7
  AST_NORM_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    req_norm && !rearm_norm |=> req_norm);                           // R7
  AST_FAST_CODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    req_fast && !rearm_fast |=> $stable(code_fast));                 // R7
  AST_NORM_REARM_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    rearm_norm && (!any_norm || !global_en) |=> !req_norm);          // R8
  AST_FAST_REARM_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    rearm_fast && (!any_fast || !global_en) |=> !req_fast);          // R8
  AST_NORM_NEEDS_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_norm) |-> $past(any_norm));                            // R2
  AST_FAST_NEEDS_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_fast) |-> $past(any_fast));                            // R2
  AST_RISE_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_norm) || $rose(req_fast) |-> $past(global_en));        // R10
  AST_FAST_UNTOUCHED: assert property (@(posedge clk) disable iff (!rst_n)
    rearm_norm && !rearm_fast && req_fast |=> $stable(code_fast) && req_fast); // R9

endmodule

bind prio_irq_arbiter prio_irq_arbiter_chk #(.NUM_BANKS(NUM_BANKS), .PRIO_W(PRIO_W)) u_chk (.*);

// File: tb/tb_prio_irq_arbiter.sv
module tb_prio_irq_arbiter;
  localparam int CLK_PERIOD = 10;
  localparam int NB = 3;
  localparam int PW = 6;
  localparam int N  = NB * 32;
  localparam int CW = $clog2(N);

  logic clk = 1'b0, rst_n = 1'b0;
  logic [N-1:0] pend = '0, mask = '1, route = '0;
  logic [N*PW-1:0] prio = '0;
  logic global_en = 1'b1, rearm_norm = 1'b0, rearm_fast = 1'b0;
  logic req_norm, req_fast;
  logic [CW-1:0] code_norm, code_fast;
  int checks = 0, fails = 0;
  logic [31:0] seed = 32'h1357_9bdf;

  prio_irq_arbiter #(.NUM_BANKS(NB), .PRIO_W(PW)) dut (
    .clk(clk), .rst_n(rst_n), .pend(pend), .mask(mask), .route_fast(route),
    .prio_vec(prio), .global_en(global_en), .rearm_norm(rearm_norm),
    .rearm_fast(rearm_fast), .req_norm(req_norm), .req_fast(req_fast),
    .code_norm(code_norm), .code_fast(code_fast));

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [31:0] nxt(logic [31:0] s);
    s ^= s << 13; s ^= s >> 17; s ^= s << 5;
    return s;
  endfunction

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic model(input bit cls, output bit any, output int win);
    int best = 0;
    any = 0; win = 0;
    for (int i = 0; i < N; i++) begin
      if (pend[i] && !mask[i] && route[i] == cls) begin
        if (!any || int'(prio[i*PW +: PW]) <= best) begin
          best = int'(prio[i*PW +: PW]);
          win = i;
        end
        any = 1;
      end
    end
  endtask

  task automatic pulse(bit rn, bit rf);
    rearm_norm = rn; rearm_fast = rf;
    @(negedge clk);
    rearm_norm = 0; rearm_fast = 0;
  endtask

  task automatic check_class(string tag, bit cls);
    bit any; int win;
    model(cls, any, win);
    if (cls) begin
      check({tag, " fast req"}, int'(req_fast), int'(any && global_en));
      if (any && global_en) check({tag, " fast code"}, int'(code_fast), win);
    end else begin
      check({tag, " norm req"}, int'(req_norm), int'(any && global_en));
      if (any && global_en) check({tag, " norm code"}, int'(code_norm), win);
    end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset norm req", int'(req_norm), 0);
    check("R1 reset fast req", int'(req_fast), 0);
    check("R1 reset norm code", int'(code_norm), 0);
    check("R1 reset fast code", int'(code_fast), 0);
    rst_n = 1;
    @(negedge clk);
    // R1: flags left reset set, so eligibility alone fires without a pulse
    mask = '0; pend[7] = 1'b1;
    @(negedge clk);
    check("R1 armed after reset", int'(req_norm), 1);
    check("R1 armed after reset code", int'(code_norm), 7);

    // R5 / R8: single line walks every position, class alternates
    for (int i = 0; i < N; i++) begin
      pend = '0; pend[i] = 1'b1; route = '0; route[i] = i[0];
      pulse(1, 1);
      check_class("R5 walk", 1'b0);
      check_class("R5 walk", 1'b1);
    end

    // R2: mask and routing decide eligibility
    pend = '1; mask = '1; mask[10] = 0; mask[70] = 0; route = '0; route[70] = 1; prio = '0;
    pulse(1, 1);
    check("R2 norm code", int'(code_norm), 10);
    check("R2 fast code", int'(code_fast), 70);
    mask = '1;
    pulse(1, 1);
    check("R2 all masked norm", int'(req_norm), 0);
    check("R2 all masked fast", int'(req_fast), 0);

    // R3: smaller value wins even from a low index
    mask = '0; route = '0; pend = '0; pend[0] = 1; pend[95] = 1;
    prio[0*PW +: PW] = 4; prio[95*PW +: PW] = 5;
    pulse(1, 1);
    check("R3 smaller wins", int'(code_norm), 0);

    // R4: equal values, highest index across banks
    prio = '0; pend = '0; pend[3] = 1; pend[40] = 1; pend[65] = 1;
    pulse(1, 1);
    check("R4 tie high index", int'(code_norm), 65);

    // R3 R4 random patterns with frequent ties
    for (int it = 0; it < 300; it++) begin
      for (int i = 0; i < N; i++) begin
        seed = nxt(seed);
        pend[i] = seed[3]; mask[i] = seed[7] & seed[9]; route[i] = seed[12];
        prio[i*PW +: PW] = PW'(seed[21:20]);
      end
      pulse(1, 1);
      check_class("R3 R4 random", 1'b0);
      check_class("R3 R4 random", 1'b1);
    end

    // R7: hold through input changes
    mask = '0; route = '0; prio = '0; pend = '0; pend[20] = 1; prio[20*PW +: PW] = 9;
    pulse(1, 1);
    check("R7 initial code", int'(code_norm), 20);
    pend[50] = 1;
    repeat (3) @(negedge clk);
    check("R7 held code", int'(code_norm), 20);
    check("R7 held req", int'(req_norm), 1);
    pend = '0;
    repeat (2) @(negedge clk);
    check("R7 held after clear", int'(req_norm), 1);
    check("R7 held code after clear", int'(code_norm), 20);
    pulse(1, 0);
    check("R8 drop on rearm", int'(req_norm), 0);

    // R6: flag kept, fires on later eligibility; R9 independence
    pend[30] = 1; pend[31] = 1; route[31] = 1;
    pulse(0, 1);
    check("R6 late fire norm", int'(code_norm), 30);
    check("R6 late fire norm req", int'(req_norm), 1);
    check("R9 fast code", int'(code_fast), 31);
    pend[60] = 1; pend[90] = 1; route[90] = 1; prio[90*PW +: PW] = 0;
    pulse(0, 1);
    check("R9 norm untouched code", int'(code_norm), 30);
    check("R9 norm untouched req", int'(req_norm), 1);
    check("R9 fast refreshed", int'(code_fast), 90);

    // R10: global enable blocks, flag retained
    global_en = 0;
    pulse(1, 1);
    check("R10 blocked norm", int'(req_norm), 0);
    check("R10 blocked fast", int'(req_fast), 0);
    repeat (2) @(negedge clk);
    check("R10 still blocked", int'(req_norm), 0);
    global_en = 1;
    @(negedge clk);
    check_class("R10 resume", 1'b0);
    check_class("R10 resume", 1'b1);

    finish_run();
  end
endmodule